// File: doc/BRIEF.md
# LVDS Transmitter Power-Up Sequencer

This block brings an LVDS transmitter from off to driving its output. It does this by issuing writes to a control-register image in a fixed order. It owns two register images: a main control image and a channel standby image. It also signals when the PLL control register has to be written. Four configuration straps decide which steps run:
- bias enable for the older generation,
- simple versus extended PLL,
- whether a power-down control exists,
- whether the PHY enable needs a separate write.

The straps, the mode field and the input-select bit are captured when a start pulse is accepted. Later changes to them have no effect on a sequence already running.

With a simple PLL the sequencer holds a timed startup wait of `WAIT_US * CLK_PER_US` clocks before its last step. The last step releases the output reset. A stop request aborts any sequence in progress, or turns off an active output. It then clears every control register and returns the block to idle. Every register write is shown by a one-cycle strobe that carries the new image. A downstream register file or bus master turns those strobes into bus accesses.

Top module: `lvds_pwrup_seq`

## Requirements
- R1: After reset, both images are zero, all three write strobes are low, and `busy` and `active` are low.
- R2: The main image is laid out as follows: bit 0 output-reset release, bit 1 PHY enable, bit 2 bias enable, bit 3 PLL on, bit 4 normal mode, bit 5 input select, bits [MODE_W+5:6] mode. A start accepted in idle produces, one cycle later, a main write holding only the captured mode and input select. The next cycle produces a channel write that sets every bit of `chan_img` (data channels in the low bits, the clock channel in the top bit).
- R3: With the bias strap set, the write after the channel write sets bias enable and PHY enable together.
- R4: With the simple-PLL strap, a write then sets PLL on. With an extended PLL the PLL-on bit is never set, and `wr_pll` is never pulsed during an enable.
- R5: With the power-down strap, normal mode is set in a write that changes no other bit.
- R6: With the PHY strap and no power-down control, PHY enable is set in its own write. With both straps, PHY enable is set in the final write together with the output-reset release.
- R7: With a simple PLL, at least `WAIT_US*CLK_PER_US` idle cycles separate the previous main write from the final write. With an extended PLL the final write follows the previous write directly.
- R8: The final write sets the output-reset release. In that same cycle `active` rises and `busy` falls. `busy` is high from the cycle after start until then.
- R9: A stop at any time moves to a clearing step. The cycle after that step, all three strobes pulse with both images zero. The block then returns to idle.
- R10: A start while busy or active is ignored. Strap, mode and input-select changes after a start do not alter that sequence.
- R11: When stop and start arrive in the same cycle, stop wins and no enable sequence begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an enable sequence (accepted only in idle) |
| stop | input | 1 | Abort or disable; clears all control registers |
| strap_gen2_bias | input | 1 | Bias and PHY enable written together after channel setup |
| strap_simple_pll | input | 1 | Simple PLL: set PLL on and apply the startup wait |
| strap_pwr_down | input | 1 | Power-down control present: set normal mode |
| strap_phy_sep | input | 1 | PHY enable needs its own step |
| mode_sel | input | MODE_W | Output mode field value |
| in_sel | input | 1 | Input select value |
| main_img | output | MODE_W+6 | Main control register image |
| chan_img | output | NUM_DATA_CH+1 | Channel standby-release image |
| wr_main | output | 1 | Main control register write strobe |
| wr_chan | output | 1 | Channel register write strobe |
| wr_pll | output | 1 | PLL control register write strobe (write of zero) |
| busy | output | 1 | Enable or clear sequence in progress |
| active | output | 1 | Output released and running |

## Verification
The enable sequence is run for all sixteen strap combinations. The resulting orderings differ in several ways: whether the bias, PLL-on, normal-mode and separate PHY writes appear, whether the timed wait appears, and whether PHY enable is merged into the final write. A mistake in any single branch therefore shows up as a wrong write in a specific cycle. Stops are applied in idle, mid-sequence during the wait, and while active. They separate abort handling from ordinary turn-off. Repeated starts with changed straps and mode while busy or active show that the captured configuration holds. A simultaneous stop and start shows which request has priority.

// File: rtl/lvds_seq_pkg.sv
package lvds_seq_pkg;

   localparam int B_OUT_REL = 0;
   localparam int B_PHY_EN  = 1;
   localparam int B_BIAS    = 2;
   localparam int B_PLL_ON  = 3;
   localparam int B_NORMAL  = 4;
   localparam int B_IN_SEL  = 5;
   localparam int B_MODE_LO = 6;

   typedef enum logic [3:0] {
      ST_IDLE, ST_MODE, ST_CHAN, ST_BIAS, ST_PLL, ST_PWD,
      ST_PHY, ST_WAIT, ST_FINAL, ST_ACTIVE, ST_CLEAR
   } seq_state_t;

   typedef struct packed {
      logic gen2_bias;
      logic simple_pll;
      logic has_pwd;
      logic phy_sep;
   } strap_t;

   typedef struct packed {
      logic                wr_main;
      logic                wr_chan;
      logic                wr_pll;
      logic                clear;
      logic                load_base;
      logic [B_IN_SEL-1:0] set_bits;
   } seq_cmd_t;

   function automatic seq_state_t raw_successor(seq_state_t s);
      case (s)
         ST_MODE: return ST_CHAN;
         ST_CHAN: return ST_BIAS;
         ST_BIAS: return ST_PLL;
         ST_PLL:  return ST_PWD;
         ST_PWD:  return ST_PHY;
         ST_PHY:  return ST_WAIT;
         default: return ST_FINAL;
      endcase
   endfunction

   function automatic logic step_applies(seq_state_t s, strap_t k);
      case (s)
         ST_BIAS: return k.gen2_bias;
         ST_PLL:  return k.simple_pll;
         ST_PWD:  return k.has_pwd;
         ST_PHY:  return k.phy_sep && !k.has_pwd;
         ST_WAIT: return k.simple_pll;
         default: return 1'b1;
      endcase
   endfunction

   function automatic seq_state_t next_step(seq_state_t s, strap_t k);
      seq_state_t n   = s;
      seq_state_t r   = ST_FINAL;
      logic       hit = 1'b0;
      for (int i = 0; i < 7; i++) begin
         n = raw_successor(n);
         if (!hit && step_applies(n, k)) begin
            r   = n;
            hit = 1'b1;
         end
      end
      return r;
   endfunction

endpackage

// File: rtl/lvds_seq_timer.sv
module lvds_seq_timer #(
   parameter int WAIT_CYC = 800
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CNT_W = $clog2(WAIT_CYC + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (!run) cnt_q <= '0;
      else          cnt_q <= cnt_q + 1'b1;
   end

   assign expired = run && (cnt_q == LAST);

   // R7: the wait never counts beyond its programmed length
   a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= LAST));
endmodule

// File: rtl/lvds_seq_ctrl.sv
module lvds_seq_ctrl
   import lvds_seq_pkg::*;
#(
   parameter int MODE_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              stop,
   input  strap_t            straps,
   input  logic [MODE_W-1:0] mode_in,
   input  logic              insel_in,
   input  logic              tmr_done,
   output seq_state_t        state,
   output strap_t            cfg,
   output logic [MODE_W-1:0] mode_q,
   output logic              insel_q,
   output seq_cmd_t          cmd,
   output logic              busy,
   output logic              active
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cfg     <= '0;
         mode_q  <= '0;
         insel_q <= 1'b0;
      end else if (state == ST_CLEAR) begin
         state <= ST_IDLE;
      end else if (stop) begin
         state <= ST_CLEAR;
      end else begin
         case (state)
            ST_IDLE: if (start) begin
               cfg     <= straps;
               mode_q  <= mode_in;
               insel_q <= insel_in;
               state   <= ST_MODE;
            end
            ST_ACTIVE: state <= ST_ACTIVE;
            ST_WAIT:   if (tmr_done) state <= ST_FINAL;
            ST_FINAL:  state <= ST_ACTIVE;
            default:   state <= next_step(state, cfg);
         endcase
      end
   end

   always_comb begin
      cmd = '0;
      if (state == ST_CLEAR) begin
         cmd.wr_main = 1'b1;
         cmd.wr_chan = 1'b1;
         cmd.wr_pll  = 1'b1;
         cmd.clear   = 1'b1;
      end else if (!stop) begin
         case (state)
            ST_MODE: begin
               cmd.wr_main   = 1'b1;
               cmd.load_base = 1'b1;
            end
            ST_CHAN: cmd.wr_chan = 1'b1;
            ST_BIAS: begin
               cmd.wr_main            = 1'b1;
               cmd.set_bits[B_BIAS]   = 1'b1;
               cmd.set_bits[B_PHY_EN] = 1'b1;
            end
            ST_PLL: begin
               cmd.wr_main            = 1'b1;
               cmd.set_bits[B_PLL_ON] = 1'b1;
            end
            ST_PWD: begin
               cmd.wr_main            = 1'b1;
               cmd.set_bits[B_NORMAL] = 1'b1;
            end
            ST_PHY: begin
               cmd.wr_main            = 1'b1;
               cmd.set_bits[B_PHY_EN] = 1'b1;
            end
            ST_FINAL: begin
               cmd.wr_main             = 1'b1;
               cmd.set_bits[B_OUT_REL] = 1'b1;
               cmd.set_bits[B_PHY_EN]  = cfg.phy_sep && cfg.has_pwd;
            end
            default: ;
         endcase
      end
   end

   assign busy   = (state != ST_IDLE) && (state != ST_ACTIVE);
   assign active = (state == ST_ACTIVE);

   // R9: a stop always leads into the clearing step
   a_r9_stop_to_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && state != ST_CLEAR) |=> (state == ST_CLEAR));
   // R10: an active output stays active until stopped
   a_r10_active_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ACTIVE && !stop) |=> (state == ST_ACTIVE));
endmodule

// File: rtl/lvds_seq_regs.sv
module lvds_seq_regs
   import lvds_seq_pkg::*;
#(
   parameter int MODE_W      = 3,
   parameter int NUM_DATA_CH = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  seq_cmd_t               cmd,
   input  logic [MODE_W-1:0]      mode_q,
   input  logic                   insel_q,
   output logic [MODE_W+5:0]      main_img,
   output logic [NUM_DATA_CH:0]   chan_img,
   output logic                   wr_main,
   output logic                   wr_chan,
   output logic                   wr_pll
);
   localparam int MAIN_W = B_MODE_LO + MODE_W;

   logic [MAIN_W-1:0] base;
   assign base = {mode_q, insel_q, {B_IN_SEL{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         main_img <= '0;
         wr_main  <= 1'b0;
         wr_chan  <= 1'b0;
         wr_pll   <= 1'b0;
      end else begin
         wr_main <= cmd.wr_main;
         wr_chan <= cmd.wr_chan;
         wr_pll  <= cmd.wr_pll;
         if (cmd.clear)          main_img <= '0;
         else if (cmd.load_base) main_img <= base;
         else if (cmd.wr_main)   main_img <= main_img | {{(MODE_W+1){1'b0}}, cmd.set_bits};
      end
   end

   for (genvar c = 0; c <= NUM_DATA_CH; c++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)           chan_img[c] <= 1'b0;
         else if (cmd.clear)   chan_img[c] <= 1'b0;
         else if (cmd.wr_chan) chan_img[c] <= 1'b1;
      end
   end

   // R5: normal mode is set by a write that changes nothing else
   a_r5_normal_alone: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_img[B_NORMAL]) |-> ((main_img ^ $past(main_img)) == MAIN_W'(1 << B_NORMAL)));
   // R3: bias and PHY enable rise in the same write
   a_r3_bias_with_phy: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_img[B_BIAS]) |-> (main_img[B_PHY_EN] && !$past(main_img[B_PHY_EN])));
endmodule

// File: rtl/lvds_pwrup_seq.sv
module lvds_pwrup_seq
   import lvds_seq_pkg::*;
#(
   parameter int MODE_W      = 3,
   parameter int NUM_DATA_CH = 4,
   parameter int CLK_PER_US  = 8,
   parameter int WAIT_US     = 100
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic                 stop,
   input  logic                 strap_gen2_bias,
   input  logic                 strap_simple_pll,
   input  logic                 strap_pwr_down,
   input  logic                 strap_phy_sep,
   input  logic [MODE_W-1:0]    mode_sel,
   input  logic                 in_sel,
   output logic [MODE_W+5:0]    main_img,
   output logic [NUM_DATA_CH:0] chan_img,
   output logic                 wr_main,
   output logic                 wr_chan,
   output logic                 wr_pll,
   output logic                 busy,
   output logic                 active
);
   localparam int WAIT_CYC = WAIT_US * CLK_PER_US;
   localparam int GAP_W    = $clog2(WAIT_CYC + 1);

   initial begin
      assert (MODE_W >= 1)      else $error("MODE_W must be at least 1");
      assert (NUM_DATA_CH >= 1) else $error("NUM_DATA_CH must be at least 1");
      assert (WAIT_CYC >= 1)    else $error("startup wait must be at least one cycle");
   end

   strap_t     straps, cfg;
   seq_state_t st;
   seq_cmd_t   cmd;
   logic [MODE_W-1:0] mode_q;
   logic       insel_q, tmr_done;

   assign straps = '{gen2_bias: strap_gen2_bias, simple_pll: strap_simple_pll,
                     has_pwd: strap_pwr_down, phy_sep: strap_phy_sep};

   lvds_seq_ctrl #(.MODE_W(MODE_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .straps(straps),
      .mode_in(mode_sel), .insel_in(in_sel), .tmr_done(tmr_done),
      .state(st), .cfg(cfg), .mode_q(mode_q), .insel_q(insel_q), .cmd(cmd),
      .busy(busy), .active(active)
   );

   lvds_seq_timer #(.WAIT_CYC(WAIT_CYC)) u_timer (
      .clk(clk), .rst_n(rst_n), .run(st == ST_WAIT), .expired(tmr_done)
   );

   lvds_seq_regs #(.MODE_W(MODE_W), .NUM_DATA_CH(NUM_DATA_CH)) u_regs (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .mode_q(mode_q), .insel_q(insel_q),
      .main_img(main_img), .chan_img(chan_img),
      .wr_main(wr_main), .wr_chan(wr_chan), .wr_pll(wr_pll)
   );

   // Cycles since the last main write, saturating; used by the R7 check.
   logic [GAP_W-1:0] gap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        gap_q <= '0;
      else if (wr_main)                  gap_q <= '0;
      else if (gap_q != GAP_W'(WAIT_CYC)) gap_q <= gap_q + 1'b1;
   end

   // R7: the release write follows the startup wait on simple-PLL parts
   a_r7_wait_gap: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(main_img[B_OUT_REL]) && cfg.simple_pll) |-> (gap_q >= GAP_W'(WAIT_CYC)));
   // R8: the release write coincides with becoming active
   a_r8_release_active: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(main_img[B_OUT_REL]) |-> (active && !busy));
   // R4: PLL-on is never set on an extended-PLL configuration
   a_r4_ext_no_pll_on: assert property (@(posedge clk) disable iff (!rst_n)
      main_img[B_PLL_ON] |-> cfg.simple_pll);
   // R4: the PLL register is written only as part of a full clear
   a_r4_pll_only_clear: assert property (@(posedge clk) disable iff (!rst_n)
      wr_pll |-> (wr_main && wr_chan && main_img == '0 && chan_img == '0));
   // R9: a stop is followed by a full clear write
   a_r9_clear_write: assert property (@(posedge clk) disable iff (!rst_n)
      (stop && st != ST_CLEAR) |=> ##1 (wr_pll && main_img == '0));
   // R2: channel release directly follows the mode write
   a_r2_chan_after_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chan_img[0]) |-> $past(wr_main));
endmodule

// File: tb/lvds_pwrup_seq_bench.sv
module lvds_pwrup_seq_bench;
   localparam int CLK_P  = 10;
   localparam int MW     = 3;
   localparam int NCH    = 4;
   localparam int CPU    = 3;
   localparam int WUS    = 4;
   localparam int WCYC   = CPU * WUS;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0, stop = 1'b0;
   logic s_bias = 1'b0, s_spll = 1'b0, s_pwd = 1'b0, s_phy = 1'b0;
   logic [MW-1:0] mode_sel = '0;
   logic in_sel = 1'b0;
   logic [MW+5:0] main_img;
   logic [NCH:0]  chan_img;
   logic wr_main, wr_chan, wr_pll, busy, active;

   always #(CLK_P/2) clk = ~clk;

   lvds_pwrup_seq #(.MODE_W(MW), .NUM_DATA_CH(NCH), .CLK_PER_US(CPU), .WAIT_US(WUS))
   u_lvds_pwrup_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
      .strap_gen2_bias(s_bias), .strap_simple_pll(s_spll),
      .strap_pwr_down(s_pwd), .strap_phy_sep(s_phy),
      .mode_sel(mode_sel), .in_sel(in_sel),
      .main_img(main_img), .chan_img(chan_img),
      .wr_main(wr_main), .wr_chan(wr_chan), .wr_pll(wr_pll),
      .busy(busy), .active(active)
   );

   int checks = 0, errors = 0;
   string tag = "R1";

   // behavioural model: -1 channel write, -2 idle wait cycle, else main write
   int q[$];
   int mst = 0;        // 0 idle, 1 running, 2 active, 3 clearing
   int e_main = 0, e_chan = 0, e_wm = 0, e_wc = 0, e_wp = 0;

   task automatic chk(string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   task automatic build_seq();
      int m;
      q.delete();
      m = (int'(mode_sel) << 6) | (int'(in_sel) << 5);
      q.push_back(m);
      q.push_back(-1);
      if (s_bias) begin m |= (1 << 2) | (1 << 1); q.push_back(m); end
      if (s_spll) begin m |= (1 << 3); q.push_back(m); end
      if (s_pwd)  begin m |= (1 << 4); q.push_back(m); end
      if (s_phy && !s_pwd) begin m |= (1 << 1); q.push_back(m); end
      if (s_spll) for (int i = 0; i < WCYC; i++) q.push_back(-2);
      m |= 1;
      if (s_phy && s_pwd) m |= (1 << 1);
      q.push_back(m);
   endtask

   task automatic model_step();
      int a;
      e_wm = 0; e_wc = 0; e_wp = 0;
      if (mst == 3) begin
         e_main = 0; e_chan = 0; e_wm = 1; e_wc = 1; e_wp = 1; mst = 0;
      end else if (stop) begin
         mst = 3; q.delete();
      end else if (mst == 0) begin
         if (start) begin build_seq(); mst = 1; end
      end else if (mst == 1) begin
         a = q.pop_front();
         if (a == -1) begin e_chan = (1 << (NCH + 1)) - 1; e_wc = 1; end
         else if (a >= 0) begin e_main = a; e_wm = 1; end
         if (q.size() == 0) mst = 2;
      end
   endtask

   task automatic compare();
      chk("main_img", int'(main_img), e_main);
      chk("chan_img", int'(chan_img), e_chan);
      chk("wr_main", int'(wr_main), e_wm);
      chk("wr_chan", int'(wr_chan), e_wc);
      chk("wr_pll", int'(wr_pll), e_wp);
      chk("busy", int'(busy), int'(mst == 1 || mst == 3));
      chk("active", int'(active), int'(mst == 2));
   endtask

   task automatic tick();
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
   endtask

   task automatic pulse_start();
      start = 1'b1; tick(); start = 1'b0;
   endtask

   task automatic pulse_stop();
      stop = 1'b1; tick(); stop = 1'b0;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      tag = "R1";
      compare();

      // R2 R3 R4 R5 R6 R7 R8 across every strap combination, then R9 turn-off
      for (int k = 0; k < 16; k++) begin
         tag = $sformatf("R2/R3/R4/R5/R6/R7/R8 straps=%0d", k);
         {s_bias, s_spll, s_pwd, s_phy} = 4'(k);
         mode_sel = MW'(k % 8);
         in_sel = k[0];
         pulse_start();
         repeat (WCYC + 12) tick();
         tag = "R9 stop while active";
         pulse_stop();
         repeat (3) tick();
      end

      // R9: abort during the startup wait
      tag = "R9 abort in wait";
      {s_bias, s_spll, s_pwd, s_phy} = 4'b1111;
      pulse_start();
      repeat (7) tick();
      pulse_stop();
      repeat (3) tick();

      // R9: abort right after the mode write, then restart cleanly
      tag = "R9 abort early";
      pulse_start();
      tick();
      pulse_stop();
      tick();
      pulse_start();
      repeat (WCYC + 12) tick();
      pulse_stop();
      repeat (3) tick();

      // R10: straps and mode changes and repeated starts ignored once running
      tag = "R10 captured config";
      {s_bias, s_spll, s_pwd, s_phy} = 4'b0101;
      mode_sel = 3'd5; in_sel = 1'b1;
      pulse_start();
      tick();
      {s_bias, s_spll, s_pwd, s_phy} = 4'b1010;
      mode_sel = 3'd2; in_sel = 1'b0;
      pulse_start();
      repeat (WCYC + 12) tick();
      tag = "R10 start while active";
      pulse_start();
      repeat (4) tick();
      pulse_stop();
      repeat (3) tick();

      // R11: stop and start together
      tag = "R11 stop beats start";
      start = 1'b1; stop = 1'b1; tick(); start = 1'b0; stop = 1'b0;
      repeat (4) tick();

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_P * 100000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule